// File: doc/BRIEF.md
# I2C Mux Channel Flush Sequencer

This block recovers the segments behind an eight-way I2C multiplexer after a reset that may have left a target device holding the data line low. When `start_i` is pulsed, the block first reads the mux control register to confirm that the expected device is present. It then enables each requested downstream channel in turn and asks an external bus clear pulse generator to run a full clear on it. The block waits for the clear to finish before it moves to the next channel.

Two external units carry out the work. A byte-level I2C command engine performs single-register reads and writes, and reports an acknowledge or an error for each one. A pulse generator drives the clock toggling on the bus and signals when it has finished. The sequencer only decides what to send and in what order. It reports `done_o` when it finishes. `skipped_o` shows that the device was missing or was the wrong device. `error_o` shows that a channel select write failed.

Top module: `mux_flush_seq`

## Requirements
- R1: One cycle after a `start_i` that is accepted in idle, the block issues a read (`cmd_rd_o`=1) of register 0x00 from the address that was on `mux_addr_i` when `start_i` was sampled. This read comes before any write.
- R2: If the probe read completes with `cmd_err_i`=1, the block issues no writes and no clears, and it finishes with `skipped_o`=1 and `error_o`=0.
- R3: If the probe read returns any value other than 0x08, the block issues no writes and no clears, and it finishes with `skipped_o`=1.
- R4: Only channels whose bit is set in the mask are processed, and they are taken from index 7 down to index 0.
- R5: Channel n is selected by a write (`cmd_rd_o`=0) of the byte 0x08 | n to register 0x00 at the mux address. Bit 3 is the enable bit and bits 2:0 hold the channel number.
- R6: Each successful select write is followed by a one-cycle `clr_start_o` pulse. No further command is issued until `clr_done_i` has been seen.
- R7: A mask of 0x00 with a successful probe finishes after the probe alone, with `skipped_o`=0 and `error_o`=0.
- R8: A request holds `cmd_req_o`, `cmd_rd_o`, `cmd_addr_o` and `cmd_wdata_o` steady until the cycle in which `cmd_ack_i` is high.
- R9: `done_o` is high for exactly one cycle, and `busy_o` is low from the next cycle. `skipped_o` and `error_o` keep their values from `done_o` until the next accepted start, which clears them.
- R10: A select write that completes with `cmd_err_i`=1 ends the sequence at once. No clear is run for that channel, and the block finishes with `error_o`=1.
- R11: `start_i` has no effect while `busy_o` is high. The latched address and mask stay in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a flush sequence (taken only when idle) |
| mux_addr_i | input | 7 | 7-bit bus address of the multiplexer |
| chan_mask_i | input | 8 | Channels to clear, bit n selects channel n |
| cmd_req_o | output | 1 | Command request to the byte engine |
| cmd_rd_o | output | 1 | 1 = register read, 0 = register write |
| cmd_addr_o | output | 7 | Target device address |
| cmd_reg_o | output | 8 | Register index (always 0x00) |
| cmd_wdata_o | output | 8 | Byte to write |
| cmd_ack_i | input | 1 | Byte engine finished the request |
| cmd_err_i | input | 1 | Request failed (no acknowledge), valid with ack |
| cmd_rdata_i | input | 8 | Read data, valid with ack |
| clr_start_o | output | 1 | One-cycle pulse that starts a bus clear |
| clr_done_i | input | 1 | Bus clear finished |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| skipped_o | output | 1 | Device absent or not the expected mux |
| error_o | output | 1 | A channel select write failed |

## Verification
The assertions check the following on every cycle: the probe comes first after an accepted start, every request stays stable until it is acknowledged, every write carries the enable pattern, and a clear starts right after each good select. They also check that a failed probe or a wrong identity leads straight to a skipped finish, that a failed write ends the sequence with the error flag, and that the picker always names the highest pending channel. Only the bench scenarios can show the properties that span a whole run. These are the complete order of channel writes for a given mask, the fact that no command is issued while a clear is still in flight, that the flags persist and are then cleared by a new start, and that a start arriving mid-sequence changes neither the address nor the channel list.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROBE,
      ST_SEL,
      ST_CLR_GO,
      ST_CLR_WAIT,
      ST_FIN
   } mfs_state_t;
endpackage

// File: rtl/mfs_chan_pick.sv
// Finds the next pending channel. The DOWNWARD option chooses the highest
// or the lowest set bit.
module mfs_chan_pick #(
   parameter int NCHAN    = 8,
   parameter bit DOWNWARD = 1'b1,
   localparam int CW      = $clog2(NCHAN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCHAN-1:0] pend_i,
   output logic             any_o,
   output logic [CW-1:0]    idx_o
);
   if (NCHAN < 2 || (NCHAN & (NCHAN - 1)) != 0) begin : g_bad_nchan
      $error("mfs_chan_pick: NCHAN must be a power of two >= 2");
   end

   assign any_o = |pend_i;

   if (DOWNWARD) begin : g_down
      always_comb begin
         idx_o = '0;
         for (int k = 0; k < NCHAN; k++) begin
            if (pend_i[k]) idx_o = CW'(k);
         end
      end
      AST_PICK_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
         any_o |-> ((pend_i >> idx_o) == NCHAN'(1))); // R4
   end else begin : g_up
      always_comb begin
         idx_o = '0;
         for (int k = NCHAN - 1; k >= 0; k--) begin
            if (pend_i[k]) idx_o = CW'(k);
         end
      end
      AST_PICK_SET: assert property (@(posedge clk) disable iff (!rst_n)
         any_o |-> pend_i[idx_o]); // R4
   end
endmodule

// File: rtl/mfs_fsm.sv
module mfs_fsm
   import mfs_pkg::*;
#(
   parameter int                ADDR_W    = 7,
   parameter int                DATA_W    = 8,
   parameter int                NCHAN     = 8,
   parameter logic [DATA_W-1:0] PROBE_REG = 8'h00,
   parameter logic [DATA_W-1:0] ID_VAL    = 8'h08,
   parameter logic [DATA_W-1:0] SEL_EN    = 8'h08,
   localparam int               CW        = $clog2(NCHAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] mux_addr_i,
   input  logic [NCHAN-1:0]  chan_mask_i,
   output logic              cmd_req_o,
   output logic              cmd_rd_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [DATA_W-1:0] cmd_reg_o,
   output logic [DATA_W-1:0] cmd_wdata_o,
   input  logic              cmd_ack_i,
   input  logic              cmd_err_i,
   input  logic [DATA_W-1:0] cmd_rdata_i,
   output logic              clr_start_o,
   input  logic              clr_done_i,
   output logic [NCHAN-1:0]  pend_o,
   input  logic              pick_any_i,
   input  logic [CW-1:0]     pick_idx_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              skipped_o,
   output logic              error_o
);
   localparam logic [DATA_W-1:0] IDX_MASK = DATA_W'(NCHAN - 1);

   if (CW > DATA_W) begin : g_bad_width
      $error("mfs_fsm: channel index does not fit in a data byte");
   end
   if ((SEL_EN & IDX_MASK) != '0) begin : g_bad_en
      $error("mfs_fsm: SEL_EN overlaps the channel number field");
   end

   mfs_state_t        state_q;
   logic [NCHAN-1:0]  pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic              skip_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         addr_q  <= '0;
         skip_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               addr_q  <= mux_addr_i;
               pend_q  <= chan_mask_i;
               skip_q  <= 1'b0;
               err_q   <= 1'b0;
               state_q <= ST_PROBE;
            end
            ST_PROBE: if (cmd_ack_i) begin
               if (cmd_err_i || cmd_rdata_i != ID_VAL) begin
                  skip_q  <= 1'b1;
                  state_q <= ST_FIN;
               end else if (!pick_any_i) begin
                  state_q <= ST_FIN;
               end else begin
                  state_q <= ST_SEL;
               end
            end
            ST_SEL: if (cmd_ack_i) begin
               if (cmd_err_i) begin
                  err_q   <= 1'b1;
                  state_q <= ST_FIN;
               end else begin
                  pend_q[pick_idx_i] <= 1'b0;
                  state_q <= ST_CLR_GO;
               end
            end
            ST_CLR_GO: state_q <= ST_CLR_WAIT;
            ST_CLR_WAIT: if (clr_done_i) begin
               state_q <= pick_any_i ? ST_SEL : ST_FIN;
            end
            ST_FIN: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_req_o   = (state_q == ST_PROBE) || (state_q == ST_SEL);
   assign cmd_rd_o    = (state_q == ST_PROBE);
   assign cmd_addr_o  = addr_q;
   assign cmd_reg_o   = PROBE_REG;
   assign cmd_wdata_o = (state_q == ST_SEL) ? (SEL_EN | DATA_W'(pick_idx_i)) : '0;
   assign clr_start_o = (state_q == ST_CLR_GO);
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_FIN);
   assign skipped_o   = skip_q;
   assign error_o     = err_q;
   assign pend_o      = pend_q;

   AST_PROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (cmd_req_o && cmd_rd_o && cmd_reg_o == PROBE_REG
                                && cmd_addr_o == $past(mux_addr_i))); // R1
   AST_PROBE_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && cmd_rd_o && cmd_ack_i && cmd_err_i) |=> (done_o && skipped_o && !error_o)); // R2
   AST_BAD_ID: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && cmd_rd_o && cmd_ack_i && !cmd_err_i && cmd_rdata_i != ID_VAL)
      |=> (done_o && skipped_o)); // R3
   AST_SEL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && !cmd_rd_o) |-> ((cmd_wdata_o & ~IDX_MASK) == SEL_EN
                                    && cmd_reg_o == PROBE_REG)); // R5
   AST_CLR_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && !cmd_rd_o && cmd_ack_i && !cmd_err_i) |=> (clr_start_o && !cmd_req_o)); // R6
   AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_start_o |=> (!clr_start_o && !cmd_req_o)); // R6
   AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && cmd_rd_o && cmd_ack_i && !cmd_err_i && cmd_rdata_i == ID_VAL && pend_q == '0)
      |=> (done_o && !skipped_o && !error_o)); // R7
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_rd_o)
                                     && $stable(cmd_addr_o) && $stable(cmd_wdata_o))); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o && $stable(skipped_o) && $stable(error_o))); // R9
   AST_WERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && !cmd_rd_o && cmd_ack_i && cmd_err_i) |=> (done_o && error_o && !clr_start_o)); // R10
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(cmd_addr_o)); // R11
endmodule

// File: rtl/mux_flush_seq.sv
module mux_flush_seq #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int NCHAN  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] mux_addr_i,
   input  logic [NCHAN-1:0]  chan_mask_i,
   output logic              cmd_req_o,
   output logic              cmd_rd_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [DATA_W-1:0] cmd_reg_o,
   output logic [DATA_W-1:0] cmd_wdata_o,
   input  logic              cmd_ack_i,
   input  logic              cmd_err_i,
   input  logic [DATA_W-1:0] cmd_rdata_i,
   output logic              clr_start_o,
   input  logic              clr_done_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              skipped_o,
   output logic              error_o
);
   localparam int CW = $clog2(NCHAN);

   logic [NCHAN-1:0] pend;
   logic             pick_any;
   logic [CW-1:0]    pick_idx;

   mfs_chan_pick #(.NCHAN(NCHAN), .DOWNWARD(1'b1)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .any_o  (pick_any),
      .idx_o  (pick_idx)
   );

   mfs_fsm #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NCHAN     (NCHAN),
      .PROBE_REG (DATA_W'(8'h00)),
      .ID_VAL    (DATA_W'(8'h08)),
      .SEL_EN    (DATA_W'(8'h08))
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .mux_addr_i  (mux_addr_i),
      .chan_mask_i (chan_mask_i),
      .cmd_req_o   (cmd_req_o),
      .cmd_rd_o    (cmd_rd_o),
      .cmd_addr_o  (cmd_addr_o),
      .cmd_reg_o   (cmd_reg_o),
      .cmd_wdata_o (cmd_wdata_o),
      .cmd_ack_i   (cmd_ack_i),
      .cmd_err_i   (cmd_err_i),
      .cmd_rdata_i (cmd_rdata_i),
      .clr_start_o (clr_start_o),
      .clr_done_i  (clr_done_i),
      .pend_o      (pend),
      .pick_any_i  (pick_any),
      .pick_idx_i  (pick_idx),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .skipped_o   (skipped_o),
      .error_o     (error_o)
   );
endmodule

// File: tb/mux_flush_seq_test.sv
`timescale 1ns/100ps
module mux_flush_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [6:0] mux_addr_i = '0;
   logic [7:0] chan_mask_i = '0;
   logic       cmd_req_o, cmd_rd_o;
   logic [6:0] cmd_addr_o;
   logic [7:0] cmd_reg_o, cmd_wdata_o;
   logic       cmd_ack_i = 1'b0, cmd_err_i = 1'b0;
   logic [7:0] cmd_rdata_i = '0;
   logic       clr_start_o, clr_done_i = 1'b0;
   logic       busy_o, done_o, skipped_o, error_o;

   always #2.5 clk = ~clk;

   mux_flush_seq uut (.*);

   int vecs = 0, bad = 0;

   // byte engine stub configuration and log
   int         ack_dly = 1;
   logic       probe_err = 1'b0;
   logic [7:0] probe_val = 8'h08;
   int         werr_at = 0;
   int         n_tx = 0;
   logic       tx_rd    [0:31];
   logic [6:0] tx_addr  [0:31];
   logic [7:0] tx_reg   [0:31];
   logic [7:0] tx_wdata [0:31];
   int         wait_cnt = 0;
   logic       have_prev = 0;
   logic [23:0] prev_req;
   int         hold_viol = 0;
   int         overlap = 0;

   // clear generator stub
   int clr_at [0:31];
   int n_clr = 0;
   int clr_busy = 0;
   int clr_cnt = 0;

   always @(negedge clk) begin
      if (cmd_ack_i) begin
         cmd_ack_i = 1'b0;
         cmd_err_i = 1'b0;
         wait_cnt  = 0;
         have_prev = 1'b0;
      end else if (cmd_req_o) begin
         if (have_prev && prev_req != {cmd_rd_o, cmd_addr_o, cmd_reg_o, cmd_wdata_o})
            hold_viol++;
         prev_req  = {cmd_rd_o, cmd_addr_o, cmd_reg_o, cmd_wdata_o};
         have_prev = 1'b1;
         if (wait_cnt < ack_dly) wait_cnt++;
         else begin
            if (n_tx < 32) begin
               tx_rd[n_tx]    = cmd_rd_o;
               tx_addr[n_tx]  = cmd_addr_o;
               tx_reg[n_tx]   = cmd_reg_o;
               tx_wdata[n_tx] = cmd_wdata_o;
            end
            if (clr_busy != 0) overlap++;
            cmd_err_i   = cmd_rd_o ? probe_err : (n_tx == werr_at);
            cmd_rdata_i = probe_val;
            cmd_ack_i   = 1'b1;
            n_tx++;
         end
      end else begin
         if (have_prev) hold_viol++;
         have_prev = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (clr_done_i) clr_done_i = 1'b0;
      if (clr_start_o) begin
         if (n_clr < 32) clr_at[n_clr] = n_tx;
         n_clr++;
         clr_busy = 1;
         clr_cnt  = 3;
      end else if (clr_busy != 0) begin
         if (clr_cnt == 0) begin
            clr_done_i = 1'b1;
            clr_busy   = 0;
         end else clr_cnt--;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vecs++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_log();
      n_tx = 0; n_clr = 0; hold_viol = 0; overlap = 0;
   endtask

   // runs one sequence; optionally pulses a second start mid-run
   task automatic run_seq(input logic [6:0] addr, input logic [7:0] mask, input bit intr,
                          output logic sk, output logic er);
      int cyc;
      clear_log();
      @(negedge clk);
      mux_addr_i = addr; chan_mask_i = mask; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (intr) begin
         repeat (3) @(negedge clk);
         mux_addr_i = ~addr; chan_mask_i = ~mask; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      cyc = 0;
      while (!done_o && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      check(done_o == 1'b1, "R9 done reached", done_o, 1);
      sk = skipped_o; er = error_o;
      @(negedge clk);
      check(!done_o && !busy_o, "R9 done one cycle then idle", {done_o, busy_o}, 0);
      check(skipped_o == sk && error_o == er, "R9 flags held after done",
            {skipped_o, error_o}, {sk, er});
   endtask

   task automatic check_probe(input logic [6:0] addr);
      check(n_tx >= 1 && tx_rd[0] == 1'b1, "R1 first command is a read", tx_rd[0], 1);
      check(tx_reg[0] == 8'h00 && tx_addr[0] == addr, "R1 probe register/address",
            {tx_addr[0], tx_reg[0]}, {addr, 8'h00});
   endtask

   task automatic t_reset();
      check(!busy_o && !done_o && !cmd_req_o && !clr_start_o && !skipped_o && !error_o,
            "R9 reset state", {busy_o, done_o, cmd_req_o, clr_start_o, skipped_o, error_o}, 0);
   endtask

   task automatic t_absent();
      logic sk, er;
      probe_err = 1'b1; probe_val = 8'h08;
      run_seq(7'h77, 8'hFF, 1'b0, sk, er);
      check_probe(7'h77);
      check(sk == 1'b1 && er == 1'b0, "R2 absent device skipped", {sk, er}, 2);
      check(n_tx == 1 && n_clr == 0, "R2 no writes or clears", n_tx * 16 + n_clr, 16);
      probe_err = 1'b0;
   endtask

   task automatic t_wrong_id(input logic [7:0] v);
      logic sk, er;
      probe_val = v;
      run_seq(7'h70, 8'h81, 1'b0, sk, er);
      check(sk == 1'b1, "R3 wrong id skipped", sk, 1);
      check(n_tx == 1 && n_clr == 0, "R3 no writes or clears", n_tx * 16 + n_clr, 16);
      probe_val = 8'h08;
   endtask

   task automatic t_empty();
      logic sk, er;
      run_seq(7'h71, 8'h00, 1'b0, sk, er);
      check_probe(7'h71);
      check(sk == 1'b0 && er == 1'b0, "R7 empty mask flags", {sk, er}, 0);
      check(n_tx == 1 && n_clr == 0, "R7 empty mask no writes", n_tx * 16 + n_clr, 16);
   endtask

   task automatic t_pattern(input logic [6:0] addr, input logic [7:0] mask, input int dly);
      logic sk, er;
      int w;
      ack_dly = dly;
      run_seq(addr, mask, 1'b0, sk, er);
      check_probe(addr);
      check(sk == 1'b0 && er == 1'b0, "R4 clean finish", {sk, er}, 0);
      check(n_tx == 1 + $countones(mask), "R4 write count", n_tx, 1 + $countones(mask));
      w = 1;
      for (int n = 7; n >= 0; n--) begin
         if (mask[n]) begin
            check(w < n_tx && tx_rd[w] == 1'b0 && tx_wdata[w] == (8'h08 | 8'(n)),
                  "R4 R5 channel order and select byte", tx_wdata[w], 8'h08 | 8'(n));
            check(tx_reg[w] == 8'h00 && tx_addr[w] == addr, "R5 select target",
                  {tx_addr[w], tx_reg[w]}, {addr, 8'h00});
            w++;
         end
      end
      check(n_clr == $countones(mask), "R6 one clear per channel", n_clr, $countones(mask));
      for (int c = 0; c < n_clr && c < 32; c++)
         check(clr_at[c] == c + 2, "R6 clear follows its select", clr_at[c], c + 2);
      check(overlap == 0, "R6 no command during clear", overlap, 0);
      check(hold_viol == 0, "R8 request held until ack", hold_viol, 0);
      ack_dly = 1;
   endtask

   task automatic t_write_err();
      logic sk, er;
      werr_at = 2;
      run_seq(7'h77, 8'hF0, 1'b0, sk, er);
      check(er == 1'b1 && sk == 1'b0, "R10 error flag", {sk, er}, 1);
      check(n_tx == 3, "R10 stops after failed write", n_tx, 3);
      check(n_clr == 1, "R10 no clear for failed channel", n_clr, 1);
      werr_at = 0;
   endtask

   task automatic t_restart();
      logic sk, er;
      run_seq(7'h55, 8'h80, 1'b1, sk, er);
      check(n_tx == 2, "R11 mid-run start ignored (count)", n_tx, 2);
      check(tx_wdata[1] == 8'h0F && tx_addr[1] == 7'h55, "R11 latched mask and address kept",
            {tx_addr[1], tx_wdata[1]}, {7'h55, 8'h0F});
      check(!busy_o, "R11 no second run started", busy_o, 0);
   endtask

   task automatic t_flags_clear();
      logic sk, er;
      probe_err = 1'b1;
      run_seq(7'h11, 8'h01, 1'b0, sk, er);
      probe_err = 1'b0;
      run_seq(7'h11, 8'h01, 1'b0, sk, er);
      check(sk == 1'b0 && er == 1'b0, "R9 new start clears flags", {sk, er}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_absent();
      t_wrong_id(8'h00);
      t_wrong_id(8'h09);
      t_empty();
      t_pattern(7'h77, 8'hA5, 1);
      t_pattern(7'h20, 8'h01, 0);
      t_pattern(7'h3C, 8'hFF, 2);
      t_pattern(7'h45, 8'h42, 6);
      t_write_err();
      t_restart();
      t_flags_clear();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      vecs++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule